// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. It divides its input clock by N = B·P + A and marks the end of every N-cycle period with a single-cycle output pulse. Internally it models a dual-modulus prescaler as a synchronous counter that runs at modulus P+1 or P. A swallow counter holds the prescaler at P+1 for its first A prescaler cycles. A main counter counts B prescaler cycles in total and ends the period.

Software-facing settings (prescaler code, A, B) are taken only at the end of a period, so a running period is never disturbed. A setting whose B is not strictly greater than A, or whose prescaler code is reserved, is refused. The previous valid settings stay in force, and an error flag is shown for the whole period that follows.

Top module: `pswallow_div`

## Requirements
- R1: The distance between consecutive rising edges of `div_pulse` is exactly B·P + A input clock cycles, where P, A and B are the settings in force for that period.
- R2: Within each period, `mod_ctl` is high for exactly A·(P+1) cycles, counted from the first cycle of the period, and low for the remaining cycles.
- R3: `div_pulse` is high for exactly one input clock cycle per period. That cycle is the last cycle of the period, and the next period begins in the following cycle with no gap.
- R4: The prescaler code on `p_code` selects P: code 0 gives P=8, code 1 gives P=16, code 2 gives P=32. Code 3 is reserved and is treated as an invalid setting.
- R5: `p_code`, `a_val` and `b_val` are sampled only at the clock edge that ends a `div_pulse` cycle. Changing them at any other time has no effect on the period in progress.
- R6: A setting with `b_val` <= `a_val`, or with code 3, is refused. The period that follows uses the previous valid settings, and `cfg_err` is high throughout it. `cfg_err` returns low after the next accepted setting.
- R7: With A = 0 every prescaler cycle uses modulus P, so `mod_ctl` stays low for the whole period and the period is B·P cycles.
- R8: While reset is asserted and right after it is released, `div_pulse` and `cfg_err` are low and `mod_ctl` is high. The first period after reset uses the built-in defaults P=8, A=1, B=2, so the first pulse appears in cycle 17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_code | input | 2 | Prescaler modulus select (0:8, 1:16, 2:32, 3 reserved) |
| a_val | input | A_W (6) | Swallow count A |
| b_val | input | B_W (13) | Main count B |
| div_pulse | output | 1 | One-cycle pulse at the last cycle of each period |
| mod_ctl | output | 1 | High while the prescaler runs at modulus P+1 |
| cfg_err | output | 1 | High for a period that follows a refused setting |

## Verification
The bench builds the block with its default parameters: 6-bit A, 13-bit B and the three prescaler moduli 8, 16 and 32. It sweeps every modulus against every A from 0 to 7, with B running from A+1 to A+3. This brings within reach the smallest legal B for each A, the A = 0 case and the highest modulus. Every period length and swallow-phase length is compared with B·P + A and A·(P+1). Further runs change the inputs in the middle of a period, and apply refused settings through both the B <= A condition and the reserved code.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

   typedef enum logic [1:0] {
      PS_8   = 2'd0,
      PS_16  = 2'd1,
      PS_32  = 2'd2,
      PS_BAD = 2'd3
   } psel_e;

endpackage

// File: rtl/pswallow_cfg.sv
// Settings stage: validates incoming settings at the period boundary and
// holds the settings in force for the running period.
module pswallow_cfg
   import pswallow_pkg::*;
#(
   parameter int A_W      = 6,
   parameter int B_W      = 13,
   parameter int RST_PSEL = 0,
   parameter int RST_A    = 1,
   parameter int RST_B    = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [1:0]     in_psel,
   input  logic [A_W-1:0] in_a,
   input  logic [B_W-1:0] in_b,
   output logic [1:0]     act_psel,
   output logic [A_W-1:0] act_a,
   output logic [B_W-1:0] act_b,
   output logic [A_W-1:0] nxt_a,
   output logic [B_W-1:0] nxt_b,
   output logic           err
);
   localparam int EXT = B_W - A_W;

   generate
      if (B_W <= A_W) begin : g_bad_width
         $error("pswallow_cfg: B_W must exceed A_W");
      end
      if (RST_B <= RST_A) begin : g_bad_rst
         $error("pswallow_cfg: reset B must exceed reset A");
      end
      if (RST_PSEL < 0 || RST_PSEL > 2) begin : g_bad_psel
         $error("pswallow_cfg: reset prescaler code out of range");
      end
   endgenerate

   logic in_ok;

   always_comb begin
      in_ok = (in_psel != PS_BAD) && (in_b > {{EXT{1'b0}}, in_a});
      nxt_a = in_ok ? in_a : act_a;
      nxt_b = in_ok ? in_b : act_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_psel <= 2'(RST_PSEL);
         act_a    <= A_W'(RST_A);
         act_b    <= B_W'(RST_B);
         err      <= 1'b0;
      end else if (load) begin
         err <= !in_ok;
         if (in_ok) begin
            act_psel <= in_psel;
            act_a    <= in_a;
            act_b    <= in_b;
         end
      end
   end

endmodule

// File: rtl/pswallow_pre.sv
// Dual-modulus prescaler model: counts P or P+1 input cycles per turn.
module pswallow_pre #(
   parameter int PC_W  = 6,
   parameter int P_MIN = 8,
   parameter int NUM_P = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] psel,
   input  logic       swallow,
   output logic       wrap
);
   generate
      if (NUM_P < 1 || NUM_P > 3) begin : g_bad_nump
         $error("pswallow_pre: NUM_P must be 1..3");
      end
      if (((P_MIN << (NUM_P - 1)) + 1) >= (1 << PC_W)) begin : g_bad_pcw
         $error("pswallow_pre: PC_W too narrow for largest modulus");
      end
   endgenerate

   logic [PC_W-1:0] p_tab [4];

   generate
      for (genvar g = 0; g < 4; g++) begin : g_tab
         if (g < NUM_P) begin : g_used
            assign p_tab[g] = PC_W'(P_MIN << g);
         end else begin : g_spare
            assign p_tab[g] = PC_W'(P_MIN);
         end
      end
   endgenerate

   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] mod_last;

   always_comb begin
      mod_last = p_tab[psel] + {{(PC_W-1){1'b0}}, swallow} - PC_W'(1);
      wrap     = (pc == mod_last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc <= '0;
      else if (wrap) pc <= '0;
      else           pc <= pc + PC_W'(1);
   end

endmodule

// File: rtl/pswallow_cnt.sv
// Swallow (A) and main (B) down-counters, stepped once per prescaler turn.
module pswallow_cnt #(
   parameter int A_W   = 6,
   parameter int B_W   = 13,
   parameter int RST_A = 1,
   parameter int RST_B = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           step,
   input  logic           load,
   input  logic [A_W-1:0] ld_a,
   input  logic [B_W-1:0] ld_b,
   output logic           a_live,
   output logic           b_last
);
   logic [A_W-1:0] a_cnt;
   logic [B_W-1:0] b_cnt;

   always_comb begin
      a_live = (a_cnt != '0);
      b_last = (b_cnt == B_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt <= A_W'(RST_A);
         b_cnt <= B_W'(RST_B);
      end else if (load) begin
         a_cnt <= ld_a;
         b_cnt <= ld_b;
      end else if (step) begin
         if (a_live) a_cnt <= a_cnt - A_W'(1);
         b_cnt <= b_cnt - B_W'(1);
      end
   end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
   import pswallow_pkg::*;
#(
   parameter int A_W      = 6,
   parameter int B_W      = 13,
   parameter int P_MIN    = 8,
   parameter int NUM_P    = 3,
   parameter int RST_PSEL = 0,
   parameter int RST_A    = 1,
   parameter int RST_B    = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     p_code,
   input  logic [A_W-1:0] a_val,
   input  logic [B_W-1:0] b_val,
   output logic           div_pulse,
   output logic           mod_ctl,
   output logic           cfg_err
);
   localparam int P_MAX = P_MIN << (NUM_P - 1);
   localparam int PC_W  = $clog2(P_MAX + 2);

   logic [1:0]     act_psel;
   logic [A_W-1:0] act_a;
   logic [B_W-1:0] act_b;
   logic [A_W-1:0] nxt_a;
   logic [B_W-1:0] nxt_b;
   logic           wrap;
   logic           a_live;
   logic           b_last;

   assign div_pulse = wrap && b_last;
   assign mod_ctl   = a_live;

   pswallow_cfg #(
      .A_W(A_W), .B_W(B_W),
      .RST_PSEL(RST_PSEL), .RST_A(RST_A), .RST_B(RST_B)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(div_pulse),
      .in_psel(p_code), .in_a(a_val), .in_b(b_val),
      .act_psel(act_psel), .act_a(act_a), .act_b(act_b),
      .nxt_a(nxt_a), .nxt_b(nxt_b), .err(cfg_err)
   );

   pswallow_pre #(
      .PC_W(PC_W), .P_MIN(P_MIN), .NUM_P(NUM_P)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .psel(act_psel),
      .swallow(a_live), .wrap(wrap)
   );

   pswallow_cnt #(
      .A_W(A_W), .B_W(B_W), .RST_A(RST_A), .RST_B(RST_B)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(wrap), .load(div_pulse),
      .ld_a(nxt_a), .ld_b(nxt_b), .a_live(a_live), .b_last(b_last)
   );

endmodule

// File: rtl/pswallow_chk.sv
module pswallow_chk #(
   parameter int A_W = 6,
   parameter int B_W = 13
) (
   input logic           clk,
   input logic           rst_n,
   input logic           div_pulse,
   input logic           mod_ctl,
   input logic           cfg_err,
   input logic [1:0]     act_psel,
   input logic [A_W-1:0] act_a,
   input logic [B_W-1:0] act_b
);
   localparam int EXT = B_W - A_W;

   a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   a_r2_swallow_start: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> (mod_ctl == (act_a != '0)));

   a_r2_no_late_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_ctl) |-> $past(div_pulse));

   a_r5_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(div_pulse) |-> ($stable(act_a) && $stable(act_b) && $stable(act_psel)));

   a_r5_err_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(div_pulse) |-> $stable(cfg_err));

   a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> ($stable(act_a) && $stable(act_b) && $stable(act_psel)));

   a_r6_active_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (act_b > {{EXT{1'b0}}, act_a}) && (act_psel != 2'd3));

   a_r7_no_swallow: assert property (@(posedge clk) disable iff (!rst_n)
      (act_a == '0) |-> !mod_ctl);

endmodule

bind pswallow_div pswallow_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .div_pulse(div_pulse), .mod_ctl(mod_ctl),
   .cfg_err(cfg_err), .act_psel(act_psel), .act_a(act_a), .act_b(act_b)
);

// File: tb/sim_pswallow_div.sv
module sim_pswallow_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  p_code = 2'd0;
   logic [5:0]  a_val = 6'd1;
   logic [12:0] b_val = 13'd2;
   logic        div_pulse, mod_ctl, cfg_err;

   int nchk = 0;
   int nbad = 0;
   int cyc  = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pswallow_div u0 (
      .clk(clk), .rst_n(rst_n), .p_code(p_code), .a_val(a_val), .b_val(b_val),
      .div_pulse(div_pulse), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_pulse();
      do @(negedge clk); while (!div_pulse);
   endtask

   // Called at a negedge where div_pulse is high; measures the next period.
   task automatic measure(output int len, output int hi, output int err0, output int w1,
                          input bit chg, input logic [1:0] cp, input int ca, input int cb);
      @(negedge clk);
      len  = 1;
      err0 = int'(cfg_err);
      w1   = int'(div_pulse);
      hi   = mod_ctl ? 1 : 0;
      while (!div_pulse) begin
         @(negedge clk);
         len++;
         if (mod_ctl) hi++;
         if (chg && len == 3) begin
            p_code = cp; a_val = 6'(ca); b_val = 13'(cb);
         end
      end
   endtask

   function automatic int pval(input int c);
      return 8 << c;
   endfunction

   task automatic apply(input int c, input int a, input int b);
      @(negedge clk);
      p_code = 2'(c); a_val = 6'(a); b_val = 13'(b);
      wait_pulse();
   endtask

   initial begin
      int len, hi, e0, w1;
      // R8 reset state
      repeat (3) @(negedge clk);
      chk(div_pulse == 1'b0, "R8 pulse in reset", int'(div_pulse), 0);
      chk(cfg_err == 1'b0, "R8 err in reset", int'(cfg_err), 0);
      chk(mod_ctl == 1'b1, "R8 mod in reset", int'(mod_ctl), 1);
      rst_n = 1'b1;
      len = 1;
      while (!div_pulse) begin @(negedge clk); len++; end
      chk(len == 17, "R8 first period", len, 17);

      // R1 R2 R3 R4 R7 sweep
      for (int c = 0; c < 3; c++) begin
         for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b <= a + 3; b++) begin
               apply(c, a, b);
               measure(len, hi, e0, w1, 1'b0, 2'd0, 0, 0);
               chk(len == b * pval(c) + a, "R1 R4 period", len, b * pval(c) + a);
               if (a == 0) chk(hi == 0, "R7 no swallow", hi, 0);
               else        chk(hi == a * (pval(c) + 1), "R2 swallow cycles", hi, a * (pval(c) + 1));
               chk(w1 == 0, "R3 pulse width", w1, 0);
               chk(e0 == 0, "R6 err low on valid", e0, 0);
            end
         end
      end

      // R5 mid-period change ignored
      apply(1, 3, 5);
      measure(len, hi, e0, w1, 1'b1, 2'd2, 2, 4);
      chk(len == 5 * 16 + 3, "R5 old period kept", len, 83);
      chk(hi == 3 * 17, "R5 old swallow kept", hi, 51);
      measure(len, hi, e0, w1, 1'b0, 2'd0, 0, 0);
      chk(len == 4 * 32 + 2, "R5 new period", len, 130);

      // R6 refused: B <= A
      apply(0, 2, 6);
      apply(0, 7, 7);
      measure(len, hi, e0, w1, 1'b0, 2'd0, 0, 0);
      chk(e0 == 1, "R6 err on B<=A", e0, 1);
      chk(len == 6 * 8 + 2, "R6 kept period", len, 50);
      chk(hi == 2 * 9, "R6 kept swallow", hi, 18);
      // R6 refused: reserved code
      apply(3, 1, 9);
      measure(len, hi, e0, w1, 1'b0, 2'd0, 0, 0);
      chk(e0 == 1, "R6 err on code 3", e0, 1);
      chk(len == 6 * 8 + 2, "R6 code 3 kept period", len, 50);
      // R6 recovery
      apply(2, 1, 3);
      measure(len, hi, e0, w1, 1'b0, 2'd0, 0, 0);
      chk(e0 == 0, "R6 err cleared", e0, 0);
      chk(len == 3 * 32 + 1, "R6 recovered period", len, 97);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      wait (cyc >= 150000);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nbad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

endmodule